// File: doc/BRIEF.md
# Packet Generator Statistics Controller

This block sits beside a test packet client. It holds the control word that starts and stops the packet generator. It also keeps six 64-bit event counters: start-of-packet, end-of-packet and error events on the transmit side, and the same three on the receive side. Software reaches all of this through a simple word-addressed register port. A write strobe carries data into the control word. A read strobe returns a 32-bit word one cycle later.

Each counter is wider than the bus, so software reads it as two halves. To get both halves from the same instant, software sets a freeze bit in the control word. This copies every live counter into a shadow register, and reads then come from the shadows while the live counters keep running. A single control code both halts the generator and zeroes every counter. A typical run starts the generator, freezes the counters and compares the transmit and receive tallies against the number of packets expected, for example 16.

Top module: `pktgen_stats`

## Requirements
- R1: After reset, `genEnable` is 0, every counter word reads 0 and the control word reads 0.
- R2: A write to byte offset 0x00 whose bits [2:0] are not 3'b100 sets `genEnable` to write-data bit 0 from the next cycle on. `genEnable` changes on no other write or cycle, except as stated in R3.
- R3: A write to offset 0x00 with bits [2:0] equal to 3'b100 drives `genEnable` to 0 and sets all six live counters to 0.
- R4: Each counter adds exactly one in every cycle its event strobe is high. The six counters are independent of one another.
- R5: The transmit counters read at these offsets, low 32 bits first and high 32 bits 4 bytes above: start-of-packet at 0x20/0x24, end-of-packet at 0x28/0x2C, error at 0x30/0x34.
- R6: The receive counters read at these offsets, in the same low/high arrangement: start-of-packet at 0x38/0x3C, end-of-packet at 0x40/0x44, error at 0x48/0x4C.
- R7: A write that changes control bit 6 from 0 to 1 copies every live counter, as it stands before that cycle's events, into its shadow. While bit 6 stays 1, counter reads return the shadows and the live counters keep counting. After bit 6 returns to 0, reads show the live values.
- R8: A clear (R3) wins over an event arriving in the same cycle. A clear issued while bit 6 is set also zeroes the shadows.
- R9: Read data appears on the cycle after the read strobe and is 0 in any cycle that follows no read. The following offsets read 0: any offset not word aligned, 0x04 to 0x1C, and 0x50 and above.
- R10: Reading offset 0x00 returns the run state in bit 0, the freeze state in bit 6, and zero in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Byte offset |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Registered read data |
| txSop | input | 1 | Transmit start-of-packet event |
| txEop | input | 1 | Transmit end-of-packet event |
| txErr | input | 1 | Transmit error event |
| rxSop | input | 1 | Receive start-of-packet event |
| rxEop | input | 1 | Receive end-of-packet event |
| rxErr | input | 1 | Receive error event |
| genEnable | output | 1 | Packet generator run enable |

## Verification
The bench sends events while the freeze bit is set and expects the old values back. A design that read the live counters, or that stopped counting underneath the shadows, would return wrong numbers after the freeze is released. The stop-and-clear write is issued in the same cycle as events on all six strobes, which catches an increment that beats the clear. A second clear is issued with the freeze active, so a stale shadow would show up. The low and high halves are read separately with non-zero counts, which exposes swapped halves or a wrong counter stride. Unaligned and unmapped offsets are probed, and so are cycles that follow a read, to confirm the read data returns to zero.

// File: rtl/pktgen_stats_pkg.sv
package pktgen_stats_pkg;
  localparam int NUM_EV = 6;
  localparam int RUN_BIT = 0;
  localparam int SNAP_BIT = 6;
  localparam logic [2:0] STOP_CLR_CODE = 3'b100;
  localparam int CTRL_OFS = 'h00;
  localparam int CNT_BASE_OFS = 'h20;

  typedef struct packed {
    logic clrAll;
    logic takeSnap;
  } ctrlStrobe_t;
endpackage

// File: rtl/pktgen_stats_ctrl.sv
module pktgen_stats_ctrl
  import pktgen_stats_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic              runQ,
  output logic              snapQ,
  output ctrlStrobe_t       strb
);
  logic wrCtrl;
  logic stopCode;

  assign wrCtrl   = busWrEn && (busAddr == ADDR_W'(CTRL_OFS));
  assign stopCode = (busWrData[2:0] == STOP_CLR_CODE);

  always_comb begin
    strb.clrAll   = wrCtrl && stopCode;
    strb.takeSnap = wrCtrl && busWrData[SNAP_BIT] && !snapQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      snapQ <= 1'b0;
    end else if (wrCtrl) begin
      runQ  <= stopCode ? 1'b0 : busWrData[RUN_BIT];
      snapQ <= busWrData[SNAP_BIT];
    end
  end
endmodule

// File: rtl/pktgen_stats_dp.sv
module pktgen_stats_dp
  import pktgen_stats_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int EV_N   = NUM_EV
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EV_N-1:0]   evVec,
  input  ctrlStrobe_t       strb,
  input  logic              runQ,
  input  logic              snapQ,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busRdData
);
  localparam int CNT_W     = 2 * DATA_W;
  localparam int WORD_W    = ADDR_W - 2;
  localparam int BASE_WORD = CNT_BASE_OFS / 4;

  logic [CNT_W-1:0]  liveCnt [EV_N];
  logic [CNT_W-1:0]  snapCnt [EV_N];
  logic [CNT_W-1:0]  viewCnt [EV_N];
  logic [WORD_W-1:0] wordIdx;
  logic [DATA_W-1:0] rdMux;

  for (genvar g = 0; g < EV_N; g++) begin : gCnt
    always_ff @(posedge clk) begin
      if (!rstN)              liveCnt[g] <= '0;
      else if (strb.clrAll)   liveCnt[g] <= '0;
      else if (evVec[g])      liveCnt[g] <= liveCnt[g] + CNT_W'(1);
    end
    always_ff @(posedge clk) begin
      if (!rstN)              snapCnt[g] <= '0;
      else if (strb.clrAll)   snapCnt[g] <= '0;
      else if (strb.takeSnap) snapCnt[g] <= liveCnt[g];
    end
    assign viewCnt[g] = snapQ ? snapCnt[g] : liveCnt[g];
  end

  assign wordIdx = busAddr[ADDR_W-1:2];

  always_comb begin
    rdMux = '0;
    if (busAddr[1:0] == 2'b00) begin
      if (wordIdx == WORD_W'(CTRL_OFS / 4)) begin
        rdMux[RUN_BIT]  = runQ;
        rdMux[SNAP_BIT] = snapQ;
      end
      for (int k = 0; k < EV_N; k++) begin
        if (wordIdx == WORD_W'(BASE_WORD + 2 * k))
          rdMux = viewCnt[k][DATA_W-1:0];
        if (wordIdx == WORD_W'(BASE_WORD + 2 * k + 1))
          rdMux = viewCnt[k][CNT_W-1:DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdData <= '0;
    else       busRdData <= busRdEn ? rdMux : '0;
  end
endmodule

// File: rtl/pktgen_stats.sv
module pktgen_stats
  import pktgen_stats_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              txSop,
  input  logic              txEop,
  input  logic              txErr,
  input  logic              rxSop,
  input  logic              rxEop,
  input  logic              rxErr,
  output logic              genEnable
);
  ctrlStrobe_t       strb;
  logic              runQ;
  logic              snapQ;
  logic [NUM_EV-1:0] evVec;

  // counter order follows the read map: tx sop/eop/err, then rx sop/eop/err
  assign evVec = {rxErr, rxEop, rxSop, txErr, txEop, txSop};
  assign genEnable = runQ;

  pktgen_stats_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .runQ(runQ), .snapQ(snapQ), .strb(strb)
  );

  pktgen_stats_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EV_N(NUM_EV)) uDp (
    .clk(clk), .rstN(rstN), .evVec(evVec), .strb(strb), .runQ(runQ),
    .snapQ(snapQ), .busRdEn(busRdEn), .busAddr(busAddr), .busRdData(busRdData)
  );
endmodule

// File: rtl/pktgen_stats_chk.sv
module pktgen_stats_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              genEnable
);
  logic wrCtrl;
  logic unmapped;
  assign wrCtrl   = busWrEn && (busAddr == '0);
  assign unmapped = (busAddr[1:0] != 2'b00) ||
                    (busAddr >= ADDR_W'('h04) && busAddr <= ADDR_W'('h1C)) ||
                    (busAddr >= ADDR_W'('h50));

  AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl && busWrData[2:0] == 3'b100 |=> !genEnable); // R3
  AST_START_RUN: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl && busWrData[2:0] != 3'b100 && busWrData[0] |=> genEnable); // R2
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrCtrl |=> $stable(genEnable)); // R2
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> busRdData == '0); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && unmapped |=> busRdData == '0); // R9
endmodule

bind pktgen_stats pktgen_stats_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
  .genEnable(genEnable)
);

// File: tb/sim_pktgen_stats.sv
`timescale 1ns/1ps
module sim_pktgen_stats;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [5:0]  ev = '0;
  logic        genEnable;

  int checks = 0, errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic [63:0] mCnt[6];
  logic [63:0] mSnap[6];
  logic        mRun = 0, mSnapOn = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  pktgen_stats u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .txSop(ev[0]), .txEop(ev[1]), .txErr(ev[2]),
    .rxSop(ev[3]), .rxEop(ev[4]), .rxErr(ev[5]), .genEnable(genEnable)
  );

  function automatic logic [31:0] modelRead(logic [7:0] a);
    logic [63:0] v;
    if (a[1:0] != 0) return 0;
    if (a == 8'h00) return {25'd0, mSnapOn, 5'd0, mRun};
    if (a >= 8'h20 && a <= 8'h4C) begin
      v = mSnapOn ? mSnap[(a - 8'h20) >> 3] : mCnt[(a - 8'h20) >> 3];
      return a[2] ? v[63:32] : v[31:0];
    end
    return 0;
  endfunction

  // one bus cycle: drive, push expectation, update the model
  task automatic step(input bit wr, input bit rd, input logic [7:0] a,
                      input logic [31:0] d, input logic [5:0] e, input string tag);
    bit clr;
    @(posedge clk); #1;
    busWrEn = wr; busRdEn = rd; busAddr = a; busWrData = d; ev = e;
    if (rd) begin expQ.push_back(modelRead(a)); tagQ.push_back(tag); end
    clr = wr && a == 0 && d[2:0] == 3'b100;
    if (wr && a == 0 && d[6] && !mSnapOn)
      for (int i = 0; i < 6; i++) mSnap[i] = mCnt[i];
    for (int i = 0; i < 6; i++) begin
      if (clr) begin mCnt[i] = 0; mSnap[i] = 0; end
      else if (e[i]) mCnt[i] = mCnt[i] + 1;
    end
    if (wr && a == 0) begin mRun = clr ? 1'b0 : d[0]; mSnapOn = d[6]; end
  endtask

  task automatic idle(input logic [5:0] e = 6'd0);
    step(0, 0, 0, 0, e, "");
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(0, 1, a, 0, 6'd0, tag);
  endtask

  task automatic readAll(input string tag);
    for (int k = 0; k < 12; k++) rd(8'h20 + 8'(k * 4), tag);
    idle(); idle();
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  // monitor: pops expectations as read data emerges
  initial begin
    bit cap = 0, prevCap = 0;
    forever begin
      @(posedge clk); cap = busRdEn;
      @(negedge clk);
      if (cap) begin
        logic [31:0] e; string t;
        e = expQ.pop_front(); t = tagQ.pop_front();
        chk(busRdData === e, t, busRdData, e);
      end else if (prevCap)
        chk(busRdData === 0, "R9 idle read data", busRdData, 0);
      prevCap = cap;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) begin mCnt[i] = 0; mSnap[i] = 0; end
    repeat (3) @(posedge clk); #1 rstN = 1;
    chk(genEnable === 0, "R1 genEnable after reset", 32'(genEnable), 0);
    readAll("R1 counters after reset");
    rd(8'h00, "R1 control after reset"); idle();

    step(1, 0, 8'h00, 32'h1, 0, ""); idle();
    chk(genEnable === 1, "R2 start", 32'(genEnable), 1);
    rd(8'h00, "R10 control run bit"); idle();

    for (int p = 0; p < 16; p++) begin
      idle(6'b001001); idle(6'b010010);
    end
    idle(6'b000100); idle(6'b000100);
    idle(6'b100000); idle(6'b100000); idle(6'b100000);
    for (int p = 0; p < 5; p++) idle(6'b111111);
    readAll("R4 R5 R6 counts after 16 packets");

    step(1, 0, 8'h00, 32'h41, 0, "");
    for (int p = 0; p < 4; p++) idle(6'b111111);
    readAll("R7 frozen shadow reads");
    rd(8'h00, "R10 control freeze bit"); idle();
    step(1, 0, 8'h00, 32'h01, 6'b101010, "");
    readAll("R7 live after release");

    step(1, 0, 8'h00, 32'h04, 6'b111111, ""); idle();
    chk(genEnable === 0, "R3 stop", 32'(genEnable), 0);
    readAll("R3 R8 clear beats event");

    step(1, 0, 8'h00, 32'h01, 0, "");
    for (int p = 0; p < 3; p++) idle(6'b111111);
    step(1, 0, 8'h00, 32'h41, 0, "");
    step(1, 0, 8'h00, 32'h44, 0, "");
    idle(6'b110011); idle(6'b110011);
    readAll("R8 clear zeroes shadow");
    step(1, 0, 8'h00, 32'h00, 0, "");
    readAll("R8 live after shadow clear");

    step(1, 0, 8'h04, 32'h01, 0, ""); idle();
    chk(genEnable === 0, "R2 write elsewhere ignored", 32'(genEnable), 0);
    rd(8'h04, "R9 unmapped 0x04"); rd(8'h1C, "R9 unmapped 0x1C");
    rd(8'h50, "R9 unmapped 0x50"); rd(8'h22, "R9 unaligned 0x22");
    rd(8'h21, "R9 unaligned 0x21"); idle(); idle(); idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule